// File: doc/BRIEF.md
# Dual-Modulus Prescaler Feedback Divider

This block divides a fast oscillator clock by an 11-bit programmable ratio and returns one narrow pulse per division period to a phase-frequency detector. The ratio is not counted by one wide full-speed counter. A small prescaler divides the input by 8 or by 9. Two slower counters run at the prescaler output rate. A program counter spans M prescaler cycles, and a swallow counter holds the prescaler in its divide-by-9 mode for the first A of them. The total ratio is N = 8*M + A, where M is the upper eight bits of the word and A is the lower three. Every integer in the legal range can be reached.

The whole block is a synchronous model clocked at the oscillator rate. A ratio word is sampled only at the end of a division period, so a change made at any other time never disturbs the period in progress. The split only works when M is at least A. For that reason any word below 56 is raised to 56, which is the smallest ratio that is legal for every value of A.

Top module: `fbdiv_dualmod`

## Requirements
- R1: While rst_ni is low, fb_o is 0.
- R2: Reset clears all counters and puts the prescaler in divide-by-9 mode. The first fb_o pulse after reset is therefore seen after exactly 9 rising edges of clk_i.
- R3: Each fb_o pulse is high for exactly one clk_i cycle.
- R4: For a word ratio_i from 56 to 2047, the distance between successive fb_o pulses is exactly N = 8*ratio_i[10:3] + ratio_i[2:0] clk_i cycles, which equals the binary value of ratio_i. This covers both ends of the range, 56 and 2047.
- R5: Any word below 56, including 0, gives a pulse distance of 56 cycles.
- R6: The word is sampled on the clk_i edge that raises fb_o. It sets the length of the interval that starts at that pulse. A change to ratio_i at any other time has no effect until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-rate clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_i | input | 11 | Total division ratio word |
| fb_o | output | 1 | Divided feedback pulse, one clk_i cycle wide |

## Verification
A division period ends on the edge where the last prescaler cycle of the program count completes. fb_o is registered, so it rises on that same edge, 9 edges after reset release for the first period and N edges after the previous pulse afterwards. The bench samples fb_o on falling edges and counts falling edges from one high sample to the next. That count equals the number of rising edges between the pulses, and the check at the first sample after each pulse confirms the one-cycle width. A word written on the falling edge where a pulse is seen cannot govern the interval already under way, which uses the word held before. The bench therefore expects the old ratio for that interval and the new ratio for the one after it. A mid-period write is checked the same way, with its offset added to the count.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  typedef enum logic {
    PS_DIV_P  = 1'b0,
    PS_DIV_P1 = 1'b1
  } ps_mode_e;
endpackage

// File: rtl/fbdiv_ratio_clamp.sv
module fbdiv_ratio_clamp #(
  parameter int N_W   = 11,
  parameter int P_LOG = 3,
  localparam int M_W  = N_W - P_LOG
) (
  input  logic [N_W-1:0]   ratio_i,
  output logic [M_W-1:0]   m_o,
  output logic [P_LOG-1:0] a_o
);
  localparam int P = 1 << P_LOG;
  localparam logic [N_W-1:0] N_MIN = N_W'(P * (P - 1));

  logic [N_W-1:0] eff;

  always_comb begin
    eff = (ratio_i < N_MIN) ? N_MIN : ratio_i;
    m_o = eff[N_W-1:P_LOG];
    a_o = eff[P_LOG-1:0];
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int P_LOG = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ps_mode_e mode_i,
  output logic     tick_o
);
  localparam int P = 1 << P_LOG;

  logic [P_LOG:0] cnt_q;
  logic [P_LOG:0] last;

  always_comb begin
    last   = (mode_i == PS_DIV_P1) ? (P_LOG+1)'(P) : (P_LOG+1)'(P - 1);
    tick_o = (cnt_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: prescaler count never passes the divide-by-(P+1) limit
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (P_LOG+1)'(P));

  // R4: count advances by one until a prescaler cycle closes
  a_r4_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
  import fbdiv_pkg::*;
#(
  parameter int M_W   = 8,
  parameter int P_LOG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [P_LOG-1:0] a_i,
  output ps_mode_e         mode_o,
  output logic             frame_end_o
);
  logic [M_W-1:0]   m_q;
  logic [P_LOG-1:0] a_q;
  ps_mode_e         mode_q;

  assign frame_end_o = tick_i && (m_q == '0);
  assign mode_o      = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= '0;
      a_q    <= '0;
      mode_q <= PS_DIV_P1;
    end else if (frame_end_o) begin
      m_q    <= m_i - 1'b1;
      a_q    <= a_i;
      mode_q <= (a_i != '0) ? PS_DIV_P1 : PS_DIV_P;
    end else if (tick_i) begin
      m_q    <= m_q - 1'b1;
      if (a_q != '0) a_q <= a_q - 1'b1;
      // a_q counts divide-by-(P+1) cycles left including the one just closed
      mode_q <= (a_q > P_LOG'(1)) ? PS_DIV_P1 : PS_DIV_P;
    end
  end

  // R4: prescaler mode only moves at a prescaler cycle boundary
  a_r4_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(mode_q));

  // R4: swallow cycles always fit inside the remaining program count
  a_r4_swallow_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(a_q) <= int'(m_q) + 1);

  // R6: loaded ratio is held between prescaler ticks
  a_r6_load_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(m_q) && $stable(a_q));

  // R4: a fresh period opens in divide-by-(P+1) mode exactly when A is nonzero
  a_r4_first_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> ((mode_q == PS_DIV_P1) == (a_q != '0)));
endmodule

// File: rtl/fbdiv_dualmod.sv
module fbdiv_dualmod
  import fbdiv_pkg::*;
#(
  parameter int N_W   = 11,
  parameter int P_LOG = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  output logic           fb_o
);
  localparam int M_W = N_W - P_LOG;

  logic [M_W-1:0]   m_ld;
  logic [P_LOG-1:0] a_ld;
  ps_mode_e         mode;
  logic             tick;
  logic             frame_end;
  logic             fb_q;

  fbdiv_ratio_clamp #(.N_W(N_W), .P_LOG(P_LOG)) i_clamp (
    .ratio_i (ratio_i),
    .m_o     (m_ld),
    .a_o     (a_ld)
  );

  fbdiv_prescaler #(.P_LOG(P_LOG)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .tick_o (tick)
  );

  fbdiv_swallow #(.M_W(M_W), .P_LOG(P_LOG)) i_swal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .m_i         (m_ld),
    .a_i         (a_ld),
    .mode_o      (mode),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= frame_end;
  end

  assign fb_o = fb_q;

  // R3: output pulse lasts a single cycle
  a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_o |=> !fb_o);

  // R5: clamped split is always legal
  a_r5_legal_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(m_ld) >= int'(a_ld));

  // R1: output low right after reset
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> !fb_o);
endmodule

// File: tb/test_fbdiv_dualmod.sv
module test_fbdiv_dualmod;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] ratio_i = 11'd100;
  logic        fb_o;

  int checks = 0;
  int fails  = 0;

  fbdiv_dualmod i_fbdiv_dualmod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .fb_o    (fb_o)
  );

  always #5ns clk_i = ~clk_i;

  function automatic int eff(int v);
    return (v < 56) ? 56 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until fb_o is seen high; also checks pulse width
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) check(fb_o == 1'b0, "R3 width", int'(fb_o), 0);
    end while (!fb_o && n < 5000);
  endtask

  initial begin
    #1_900_000ns;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int prev;
    repeat (4) @(negedge clk_i);
    check(fb_o == 1'b0, "R1 reset", int'(fb_o), 0);
    rst_ni = 1'b1;
    wait_pulse(n);
    check(n == 9, "R2 first pulse", n, 9);
    wait_pulse(n);
    check(n == 100, "R4 period", n, 100);
    prev = 100;

    for (int v = 0; v < 128; v++) begin
      ratio_i = 11'(v);
      wait_pulse(n);
      check(n == prev, "R6 old ratio holds", n, prev);
      wait_pulse(n);
      if (v < 56) check(n == 56, "R5 clamp", n, 56);
      else        check(n == v, "R4 period", n, v);
      prev = eff(v);
    end

    for (int v = 128; v < 2047; v += 61) begin
      ratio_i = 11'(v);
      wait_pulse(n);
      check(n == prev, "R6 old ratio holds", n, prev);
      wait_pulse(n);
      check(n == v, "R4 period", n, v);
      prev = v;
    end

    for (int v = 2046; v <= 2047; v++) begin
      ratio_i = 11'(v);
      wait_pulse(n);
      check(n == prev, "R6 old ratio holds", n, prev);
      wait_pulse(n);
      check(n == v, "R4 max range", n, v);
      prev = v;
    end

    // mid-period change: current interval keeps the old word
    ratio_i = 11'd300;
    wait_pulse(n);
    check(n == prev, "R6 old ratio holds", n, prev);
    repeat (20) @(negedge clk_i);
    ratio_i = 11'd700;
    wait_pulse(n);
    check(n + 20 == 300, "R6 mid change ignored", n + 20, 300);
    wait_pulse(n);
    check(n == 700, "R6 new ratio applied", n, 700);

    // reset in mid-period, then low again and restart
    repeat (50) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(fb_o == 1'b0, "R1 reset", int'(fb_o), 0);
    ratio_i = 11'd56;
    rst_ni = 1'b1;
    wait_pulse(n);
    check(n == 9, "R2 first pulse", n, 9);
    wait_pulse(n);
    check(n == 56, "R4 min range", n, 56);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule